// File: doc/BRIEF.md
# Receive Character Queue with Head Status

This block is the receive-side holding queue of a serial controller. Every character the receiver assembles is pushed into the queue together with a six-bit word of error and framing flags. By default the queue holds 32 entries. The processor pops characters one at a time through a data-register read strobe. While a character sits at the head, its own flags are shown in an 8-bit current-status view, so software always sees the condition of the character it is about to take.

The data byte and the status view are both decoded from one head pointer, and popping moves them together. A protocol-mode input sets which flags are meaningful. Flags that the active mode does not use are forced to zero in the view. A receiver reset command, a channel reset command, or the system-stop level each empty the queue. None of the outputs is an interrupt.

If the receiver writes a character while the queue is full, that character is discarded. The loss is recorded in the overrun flag of the newest character still held, so software reaches the overrun mark just after the last good character before the gap.

Top module: `rxq_status_fifo`

## Requirements
- R1: After `rst_n` is low, and after any cycle in which `cmd_rx_reset`, `cmd_chan_reset` or `sys_stop` is high, the queue is empty: `data_present` is 0, `cur_stat` is 8'h00 and `cpu_rd_data` is 8'h00.
- R2: `cur_stat[0]` and `data_present` are 1 exactly when at least one character is held, and 0 otherwise.
- R3: `cur_stat[1]` always reads 0.
- R4: While the queue is non-empty, `cpu_rd_data` is the oldest character and `cur_stat[7:2]` is that character's stored flags `rx_wr_stat[5:0]` (flag k appears at view bit k+2), after the mode mask. While the queue is empty, `cur_stat` and `cpu_rd_data` read all zero.
- R5: Characters leave in the order they were written. A pulse on `cpu_rd_data_stb` pops one character, and data and status advance together to the next character.
- R6: The queue holds exactly DEPTH (default 32) characters. A write while it is full, with no pop in the same cycle, is dropped and sets flag 1 (overrun, view bit 3) of the most recently stored character.
- R7: Mode mask. With `proto_mode`=0 (async), only flags 4 (parity), 3 (framing) and 1 (overrun) are shown. With 1 (byte-sync), only flags 4 (parity), 1 (overrun) and 0 (CRC) are shown. With 2 or 3 (HDLC), all six are shown: 5 end-of-message, 4 short frame, 3 abort, 2 residual bits, 1 overrun, 0 CRC. The mask applies to the view only; the stored flags are kept.
- R8: A write and a pop in the same cycle keep the occupancy unchanged and move the head to the next character. This includes a queue holding one entry, and a full queue, where the write is accepted.
- R9: A pop strobe while the queue is empty has no effect, and a write in that cycle is still stored.
- R10: A clear condition takes priority over a write in the same cycle: the written character is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr_en | input | 1 | Receiver delivers one character this cycle |
| rx_wr_data | input | DATA_W | Received character |
| rx_wr_stat | input | 6 | Flags belonging to the character |
| cpu_rd_data_stb | input | 1 | Processor read of the data register; pops the head |
| proto_mode | input | 2 | 0 async, 1 byte-sync, 2 or 3 HDLC |
| cmd_rx_reset | input | 1 | Receiver reset command, empties the queue |
| cmd_chan_reset | input | 1 | Channel reset command, empties the queue |
| sys_stop | input | 1 | System-stop level; the queue is held empty while high |
| cpu_rd_data | output | DATA_W | Head character, zero when empty |
| cur_stat | output | 8 | Current status: [7:2] masked head flags, [1] zero, [0] data present |
| data_present | output | 1 | At least one character is held |

## Verification
Every output is decoded combinationally from registers. A write, pop or clear sampled at one rising edge is therefore visible once that edge has passed, and a change of `proto_mode` shows in the view with no clock at all. The bench changes inputs on the falling edge, lets exactly one rising edge take them, and compares all three outputs at the next falling edge against a queue model it updates for that same edge. Mode-only steps run with the queue idle, so the comparison isolates the mask.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int STAT_W   = 6;
   localparam int VIEW_W   = STAT_W + 2;
   localparam int OVR_FLAG = 1;

   typedef enum logic [1:0] {
      RXQ_ASYNC = 2'd0,
      RXQ_BSYNC = 2'd1,
      RXQ_HDLC  = 2'd2,
      RXQ_HDLC2 = 2'd3
   } rxq_mode_e;

   // flags a protocol mode lets through to the status view
   function automatic logic [STAT_W-1:0] mode_mask(input rxq_mode_e m);
      case (m)
         RXQ_ASYNC: mode_mask = 6'b011010;
         RXQ_BSYNC: mode_mask = 6'b010011;
         default:   mode_mask = 6'b111111;
      endcase
   endfunction

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push_req,
   input  logic          pop_req,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [AW-1:0] last_idx,
   output logic          push_ok,
   output logic          drop,
   output logic          not_empty
);

   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] fill_q;
   logic          full, pop_ok;

   assign not_empty = (fill_q != '0);
   assign full      = (fill_q == CW'(DEPTH));
   assign pop_ok    = pop_req && not_empty;
   assign push_ok   = push_req && (!full || pop_ok);
   assign drop      = push_req && full && !pop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
         fill_q <= fill_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   assign wr_idx   = wr_ptr_q;
   assign rd_idx   = rd_ptr_q;
   assign last_idx = wr_ptr_q - AW'(1);

endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              push_ok,
   input  logic              drop,
   input  logic [AW-1:0]     wr_idx,
   input  logic [AW-1:0]     rd_idx,
   input  logic [AW-1:0]     last_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STAT_W-1:0] wr_stat,
   output logic [DATA_W-1:0] head_data,
   output logic [STAT_W-1:0] head_stat
);

   logic [DEPTH-1:0][DATA_W-1:0] data_all;
   logic [DEPTH-1:0][STAT_W-1:0] stat_all;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] d_q;
      logic [STAT_W-1:0] s_q;

      always_ff @(posedge clk) begin
         if (push_ok && (wr_idx == AW'(i))) begin
            d_q <= wr_data;
            s_q <= wr_stat;
         end else if (drop && (last_idx == AW'(i))) begin
            s_q[OVR_FLAG] <= 1'b1;
         end
      end

      assign data_all[i] = d_q;
      assign stat_all[i] = s_q;
   end

   // one index selects both halves of the head entry
   assign head_data = data_all[rd_idx];
   assign head_stat = stat_all[rd_idx];

endmodule

// File: rtl/rxq_view.sv
module rxq_view
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  rxq_mode_e         mode,
   input  logic              not_empty,
   input  logic [DATA_W-1:0] head_data,
   input  logic [STAT_W-1:0] head_stat,
   output logic [DATA_W-1:0] rd_data,
   output logic [VIEW_W-1:0] view,
   output logic              present
);

   logic [STAT_W-1:0] shown;

   assign shown   = head_stat & mode_mask(mode);
   assign present = not_empty;
   assign rd_data = not_empty ? head_data : '0;
   assign view    = not_empty ? {shown, 1'b0, 1'b1} : '0;

endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_wr_en,
   input  logic [DATA_W-1:0] rx_wr_data,
   input  logic [5:0]        rx_wr_stat,
   input  logic              cpu_rd_data_stb,
   input  logic [1:0]        proto_mode,
   input  logic              cmd_rx_reset,
   input  logic              cmd_chan_reset,
   input  logic              sys_stop,
   output logic [DATA_W-1:0] cpu_rd_data,
   output logic [7:0]        cur_stat,
   output logic              data_present
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_status_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_status_fifo: DATA_W must be positive");
   end

   logic              clr, push_req, pop_req;
   logic [AW-1:0]     wr_idx, rd_idx, last_idx;
   logic              push_ok, drop, not_empty;
   logic [DATA_W-1:0] head_data;
   logic [STAT_W-1:0] head_stat;

   assign clr      = cmd_rx_reset | cmd_chan_reset | sys_stop;
   assign push_req = rx_wr_en & ~clr;
   assign pop_req  = cpu_rd_data_stb & ~clr;

   rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .push_req (push_req),
      .pop_req  (pop_req),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .last_idx (last_idx),
      .push_ok  (push_ok),
      .drop     (drop),
      .not_empty(not_empty)
   );

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .push_ok  (push_ok),
      .drop     (drop),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .last_idx (last_idx),
      .wr_data  (rx_wr_data),
      .wr_stat  (rx_wr_stat),
      .head_data(head_data),
      .head_stat(head_stat)
   );

   rxq_view #(.DATA_W(DATA_W)) u_view (
      .mode     (rxq_mode_e'(proto_mode)),
      .not_empty(not_empty),
      .head_data(head_data),
      .head_stat(head_stat),
      .rd_data  (cpu_rd_data),
      .view     (cur_stat),
      .present  (data_present)
   );

endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_wr_en,
   input logic              cpu_rd_data_stb,
   input logic [1:0]        proto_mode,
   input logic              cmd_rx_reset,
   input logic              cmd_chan_reset,
   input logic              sys_stop,
   input logic [DATA_W-1:0] cpu_rd_data,
   input logic [7:0]        cur_stat,
   input logic              data_present
);

   logic any_clr;
   assign any_clr = cmd_rx_reset || cmd_chan_reset || sys_stop;

   // R3
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_stat[1] == 1'b0);

   // R2
   present_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_stat[0] == data_present);

   // R4
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_present |-> (cur_stat == 8'h00 && cpu_rd_data == '0));

   // R1
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_clr |=> !data_present);

   // R7
   async_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_mode == 2'd0) |-> (cur_stat[7] == 1'b0 && cur_stat[4] == 1'b0 && cur_stat[2] == 1'b0));

   // R8
   write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wr_en && !any_clr) |=> data_present);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_wr_en && !cpu_rd_data_stb && !any_clr) |=> ($stable(data_present) && $stable(cpu_rd_data)));

endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_wr_en       (rx_wr_en),
   .cpu_rd_data_stb(cpu_rd_data_stb),
   .proto_mode     (proto_mode),
   .cmd_rx_reset   (cmd_rx_reset),
   .cmd_chan_reset (cmd_chan_reset),
   .sys_stop       (sys_stop),
   .cpu_rd_data    (cpu_rd_data),
   .cur_stat       (cur_stat),
   .data_present   (data_present)
);

// File: tb/test_rxq_status_fifo.sv
`timescale 1ns/1ps
module test_rxq_status_fifo;

   localparam int DEPTH = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_wr_en = 1'b0;
   logic [7:0] rx_wr_data = '0;
   logic [5:0] rx_wr_stat = '0;
   logic       cpu_rd_data_stb = 1'b0;
   logic [1:0] proto_mode = 2'd2;
   logic       cmd_rx_reset = 1'b0, cmd_chan_reset = 1'b0, sys_stop = 1'b0;
   logic [7:0] cpu_rd_data, cur_stat;
   logic       data_present;

   int vectors = 0;
   int errors  = 0;
   logic [13:0] q[$];

   always #10 clk = ~clk;

   rxq_status_fifo #(.DEPTH(DEPTH), .DATA_W(8)) i_rxq_status_fifo (
      .clk(clk), .rst_n(rst_n), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
      .rx_wr_stat(rx_wr_stat), .cpu_rd_data_stb(cpu_rd_data_stb), .proto_mode(proto_mode),
      .cmd_rx_reset(cmd_rx_reset), .cmd_chan_reset(cmd_chan_reset), .sys_stop(sys_stop),
      .cpu_rd_data(cpu_rd_data), .cur_stat(cur_stat), .data_present(data_present));

   function automatic logic [5:0] exp_mask(input logic [1:0] m);
      case (m)
         2'd0:    return 6'b011010;
         2'd1:    return 6'b010011;
         default: return 6'b111111;
      endcase
   endfunction

   function automatic logic [7:0] exp_view(input logic [1:0] m, input int n, input logic [13:0] h);
      if (n == 0) return 8'h00;
      return {h[5:0] & exp_mask(m), 1'b0, 1'b1};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [13:0] h;
      h = (q.size() > 0) ? q[0] : 14'h0;
      chk(tag, "data_present", 32'(data_present), 32'(q.size() > 0));
      chk(tag, "cur_stat", 32'(cur_stat), 32'(exp_view(proto_mode, q.size(), h)));
      chk(tag, "cpu_rd_data", 32'(cpu_rd_data), (q.size() > 0) ? 32'(h[13:6]) : 32'h0);
   endtask

   // inputs applied at a falling edge, one rising edge takes them, compared at the next falling edge
   task automatic step(input logic wr, input logic [7:0] d, input logic [5:0] s,
                       input logic rd, input logic [2:0] clr, input string tag);
      logic pop, full;
      rx_wr_en = wr; rx_wr_data = d; rx_wr_stat = s; cpu_rd_data_stb = rd;
      {cmd_rx_reset, cmd_chan_reset, sys_stop} = clr;
      @(posedge clk);
      if (clr != 3'b000) begin
         q.delete();
      end else begin
         pop  = rd && (q.size() > 0);
         full = (q.size() == DEPTH);
         if (wr && full && !pop) q[q.size()-1][1] = 1'b1;
         if (pop) void'(q.pop_front());
         if (wr && (!full || pop)) q.push_back({d, s});
      end
      @(negedge clk);
      rx_wr_en = 1'b0; cpu_rd_data_stb = 1'b0;
      {cmd_rx_reset, cmd_chan_reset, sys_stop} = 3'b000;
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : main
      int sz;
      logic [1:0] tmp;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      compare("R1");                         // reset held
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R4 single entry, all flags in HDLC mode, then pop to empty
      proto_mode = 2'd2;
      step(1, 8'hA5, 6'h3F, 0, 3'b000, "R4");
      chk("R2", "cur_stat[0]", 32'(cur_stat[0]), 32'h1);
      chk("R3", "cur_stat[1]", 32'(cur_stat[1]), 32'h0);
      step(0, 8'h00, 6'h00, 1, 3'b000, "R4");

      // R7 mask per mode over one stored entry
      step(1, 8'h3C, 6'h3F, 0, 3'b000, "R7");
      for (int m = 0; m < 4; m++) begin
         proto_mode = 2'(m);
         #1;
         chk("R7", "cur_stat", 32'(cur_stat), 32'(exp_view(2'(m), 1, {8'h3C, 6'h3F})));
      end
      proto_mode = 2'd2;
      step(0, 0, 0, 1, 3'b000, "R4");

      // R9 pop while empty, write in same cycle kept
      step(0, 0, 0, 1, 3'b000, "R9");
      step(1, 8'h11, 6'h04, 1, 3'b000, "R9");

      // R8 one entry, write and pop together
      step(1, 8'h22, 6'h20, 1, 3'b000, "R8");
      step(0, 0, 0, 1, 3'b000, "R8");

      // R5/R6 fill to capacity, overflow, drain in order
      for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h40), 6'(i % 3), 0, 3'b000, "R5");
      step(1, 8'hFF, 6'h00, 0, 3'b000, "R6");
      step(1, 8'hFE, 6'h00, 1, 3'b000, "R8");    // full + pop: write accepted
      for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 3'b000, "R5");

      // R10 each clear source beats a same-cycle write
      step(1, 8'h01, 6'h01, 0, 3'b000, "R1");
      step(1, 8'h02, 6'h02, 0, 3'b100, "R10");
      step(1, 8'h03, 6'h03, 0, 3'b000, "R1");
      step(1, 8'h04, 6'h04, 0, 3'b010, "R10");
      step(1, 8'h05, 6'h05, 0, 3'b000, "R1");
      step(1, 8'h06, 6'h06, 1, 3'b001, "R10");

      // random traffic, alternating fill-heavy and drain-heavy phases
      for (int n = 0; n < 3000; n++) begin
         int wp;
         wp = ((n / 250) % 2 == 0) ? 85 : 30;
         if ($urandom_range(31, 0) == 0) begin
            tmp = 2'($urandom_range(3, 0));
            proto_mode = tmp;
         end
         step(($urandom_range(99, 0) < wp), 8'($urandom), 6'($urandom),
              ($urandom_range(99, 0) < 100 - wp),
              ($urandom_range(127, 0) == 0) ? 3'(1 << $urandom_range(2, 0)) : 3'b000,
              "R5");
      end
      sz = q.size();
      $display("  final occupancy %0d", sz);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule